// File: doc/BRIEF.md
# Multi-Channel Alarm Status Register Bank

This block gathers the alarm signals of four line-interface channels and presents them to a host as one 8-bit status register per channel. Every channel carries four alarm inputs: driver monitor, loss of signal, line code violation and transmit clock loss. All sixteen inputs are treated as asynchronous and pass through a two-flop synchroniser. Each register shows the synchronised live level of every alarm. It also holds a sticky flag per alarm that records any change of that alarm, in either direction, since the register was last read.

The host reads through a small parallel port. It drives a 4-bit address together with a read strobe, and the matching register appears on the 8-bit read data bus in the same cycle. The clock edge that ends the strobe clears the sticky half of the addressed register. The live half is never touched. A single interrupt output stays high while any sticky flag in any channel is set.

Each channel holds a two-state machine:
- QUIET: no sticky flag is set. The QUIET to FLAGGED transition is taken on any detected change.
- FLAGGED: at least one flag is set. The FLAGGED to QUIET transition is taken when a clearing read leaves no flag set.

The interrupt is the OR of the FLAGGED indications of all channels.

Top module: `alarm_status_bank`

## Requirements
- R1: Register bits 7..4 hold the live alarm levels in the order driver monitor (7), loss of signal (6), line code violation (5), transmit clock loss (4). Input `alarm_in[4*c+3]`..`alarm_in[4*c]` of channel c map to bits 7..4. A live bit follows its input two clock edges after the input changes.
- R2: Register bits 3..0 are sticky flags for the same four alarms in the same order. A rising alarm sets its flag three clock edges after the input changes.
- R3: A falling alarm also sets its flag.
- R4: A read strobe on a channel's address returns its register and clears that channel's sticky bits at the next clock edge. Live bits and other channels are unaffected.
- R5: Channel addresses are 0x2 for channel 0, 0x5 for channel 1, 0x8 for channel 2 and 0xB for channel 3.
- R6: After reset, every register reads 0x00 and `irq` is low.
- R7: If an alarm change lands on the same clock edge as a clearing read of its channel, the flag for that alarm is set after the edge.
- R8: `irq` is high while any sticky flag of any channel is set, and falls only once every flag has been cleared.
- R9: A read of any other address, or any cycle without the read strobe, gives `rd_data` = 0x00 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_in | input | 16 | Raw alarm levels, four per channel, channel c at bits 4c+3..4c |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | 8 | Read data, combinational from address and strobe |
| irq | output | 1 | Interrupt, high while any sticky flag is set |

## Verification
The bench drives an alarm input at a falling clock edge. The live bit is due after the second rising edge and the sticky flag and `irq` after the third, so the bench samples at the falling edge that follows each of those counts. Read data is combinational, so the bench samples it a short delay after raising the strobe and before the clearing edge, and checks the cleared state at the next falling edge. The collision case reads exactly at the second falling edge after a toggle, so that the change detection and the clear share the third rising edge.

// File: rtl/alarm_status_pkg.sv
package alarm_status_pkg;

    localparam int NUM_CH  = 4;
    localparam int NUM_ALM = 4;
    localparam int ADDR_W  = 4;

    typedef enum logic {
        CH_QUIET   = 1'b0,
        CH_FLAGGED = 1'b1
    } ch_state_t;

    // Register address of channel ch: 2, 5, 8, 11
    function automatic int ch_addr(input int ch);
        return 2 + 3 * ch;
    endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[b] <= 1'b0;
                    sync_q[b] <= 1'b0;
                end else begin
                    meta_q[b] <= async_i[b];
                    sync_q[b] <= meta_q[b];
                end
            end
        end
    endgenerate

    assign sync_o = sync_q;

    // Live level is the first stage delayed by one edge (R1)
    assert_live_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_q == $past(meta_q));

endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_status_pkg::*;
#(
    parameter int NUM_ALM_P = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_ALM_P-1:0] live_i,
    input  logic                 clr_i,
    output logic [NUM_ALM_P-1:0] sticky_o,
    output logic                 flagged_o
);

    logic [NUM_ALM_P-1:0] prev_q;
    logic [NUM_ALM_P-1:0] sticky_q;
    logic [NUM_ALM_P-1:0] change;
    logic [NUM_ALM_P-1:0] sticky_d;
    ch_state_t            state_q, state_d;

    assign change   = live_i ^ prev_q;
    // A change wins over a clear in the same cycle
    assign sticky_d = (clr_i ? '0 : sticky_q) | change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            sticky_q <= '0;
        end else begin
            prev_q   <= live_i;
            sticky_q <= sticky_d;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_QUIET:   if (|change)                   state_d = CH_FLAGGED;
            CH_FLAGGED: if (clr_i && (sticky_d == '0)) state_d = CH_QUIET;
            default:                                   state_d = CH_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        flagged_o = (state_q == CH_FLAGGED);
        sticky_o  = sticky_q;
    end

    // A detected change leaves its flag set, whatever the read (R2, R3, R7)
    assert_change_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (change != '0) |=> ((sticky_q & $past(change)) == $past(change)));

    // Without a clear no flag drops (R4)
    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // The state machine agrees with the flag bank (R8)
    assert_state_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_QUIET) == (sticky_q == '0));

endmodule

// File: rtl/alarm_status_bank.sv
module alarm_status_bank
    import alarm_status_pkg::*;
#(
    parameter int NUM_CH_P  = NUM_CH,
    parameter int NUM_ALM_P = NUM_ALM,
    parameter int ADDR_W_P  = ADDR_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CH_P*NUM_ALM_P-1:0]   alarm_in,
    input  logic                            rd_en,
    input  logic [ADDR_W_P-1:0]             rd_addr,
    output logic [2*NUM_ALM_P-1:0]          rd_data,
    output logic                            irq
);

    localparam int TOTAL  = NUM_CH_P * NUM_ALM_P;
    localparam int DATA_W = 2 * NUM_ALM_P;

    logic [TOTAL-1:0]    live_all;
    logic [NUM_CH_P-1:0] hit;
    logic [NUM_CH_P-1:0] flagged;
    logic [DATA_W-1:0]   word [NUM_CH_P];

    alarm_sync #(.WIDTH(TOTAL)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(alarm_in),
        .sync_o (live_all)
    );

    generate
        for (genvar c = 0; c < NUM_CH_P; c++) begin : g_ch
            logic [NUM_ALM_P-1:0] live_c;
            logic [NUM_ALM_P-1:0] sticky_c;

            assign live_c = live_all[c*NUM_ALM_P +: NUM_ALM_P];
            assign hit[c] = rd_en && (rd_addr == ADDR_W_P'(ch_addr(c)));

            alarm_channel #(.NUM_ALM_P(NUM_ALM_P)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .live_i   (live_c),
                .clr_i    (hit[c]),
                .sticky_o (sticky_c),
                .flagged_o(flagged[c])
            );

            assign word[c] = hit[c] ? {live_c, sticky_c} : '0;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH_P; c++) rd_data = rd_data | word[c];
    end

    assign irq = |flagged;

    // At most one channel decodes any address (R5)
    assert_one_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // No decoded channel means an empty bus (R9)
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (rd_data == '0));

    // irq drops only on the edge of a read (R8)
    assert_irq_fall_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en));

endmodule

// File: tb/alarm_status_bank_test.sv
module alarm_status_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alarm_in = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    logic [3:0] m_live   [4];
    logic [3:0] m_sticky [4];

    always #5 clk = ~clk;

    alarm_status_bank uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm_in(alarm_in),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [3:0] addr_of(input int c);
        return 4'(2 + 3 * c);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int c = 0; c < 4; c++) r = r | (|m_sticky[c]);
        return r;
    endfunction

    // Read at a falling edge, sample before the clearing edge, return at the next falling edge
    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_chan(input int c, input string req);
        logic [7:0] d;
        do_read(addr_of(c), d);
        check(req, d, {m_live[c], m_sticky[c]});
        m_sticky[c] = '0;
    endtask

    // Toggle alarm a of channel c and wait until the flag has landed
    task automatic toggle(input int c, input int a);
        alarm_in[4*c+a] = ~alarm_in[4*c+a];
        m_live[c][a]    = ~m_live[c][a];
        m_sticky[c][a]  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int c = 0; c < 4; c++) begin m_live[c] = '0; m_sticky[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6, R5: reset state on every mapped address
        check("R6 irq", {7'd0, irq}, 8'h00);
        for (int c = 0; c < 4; c++) read_chan(c, "R6 reset read");

        // R1, R2, R3, R4: sweep every channel and alarm, both directions
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 4; a++) begin
                toggle(c, a);
                check("R8 irq after rise", {7'd0, irq}, 8'h01);
                read_chan(c, "R2 rising flag");
                read_chan(c, "R4 cleared, live kept");
                check("R8 irq low", {7'd0, irq}, {7'd0, model_irq()});
                toggle(c, a);
                read_chan(c, "R3 falling flag");
                read_chan(c, "R4 cleared after fall");
            end
        end

        // R4, R8: clear of one channel leaves others and irq
        toggle(1, 2);
        toggle(3, 0);
        read_chan(1, "R5 channel 1");
        check("R8 irq held by ch3", {7'd0, irq}, 8'h01);
        read_chan(3, "R4 channel 3 untouched by ch1 read");
        check("R8 irq cleared", {7'd0, irq}, 8'h00);

        // R9: unmapped addresses with flags pending on every channel
        for (int c = 0; c < 4; c++) toggle(c, 3 - c);
        for (int a = 0; a < 16; a++) begin
            if (a != 2 && a != 5 && a != 8 && a != 11) begin
                do_read(4'(a), d);
                check("R9 unmapped zero", d, 8'h00);
            end
        end
        check("R9 no strobe zero", rd_data, 8'h00);
        for (int c = 0; c < 4; c++) read_chan(c, "R9 flags kept");
        check("R8 irq after all reads", {7'd0, irq}, 8'h00);

        // R1, R7: live after two edges, read collides with change detection
        alarm_in[4*2+1] = ~alarm_in[4*2+1];
        m_live[2][1]    = ~m_live[2][1];
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_read(addr_of(2), d);
        check("R1 live after two edges", d, {m_live[2], 4'b0000});
        m_sticky[2] = 4'b0010;
        check("R7 irq after collision", {7'd0, irq}, 8'h01);
        read_chan(2, "R7 flag survives clear");
        check("R8 irq final", {7'd0, irq}, 8'h00);

        // R6: reset again clears live bits
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin m_live[c] = '0; m_sticky[c] = '0; end
        alarm_in = '0;
        read_chan(0, "R6 after re-reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule